// File: doc/BRIEF.md
# Synchronous Serial Master/Slave Port

This block is a full-duplex synchronous serial port that can act as the clock master or as a clocked slave. A single shift register sends the outgoing word and collects the incoming word together, so every transfer swaps one word for another whether or not either side has meaningful data. The host writes a transmit word and reads the received word through a plain strobe-and-data interface. A receive-complete flag signals each finished word.

Word width (2 to 16 bits), bit order, idle clock level and clock phase are programmable. A master paces its serial clock from a one-cycle `baud_tick` input, with two ticks per bit. A slave takes its clock and data from the pins through a two-stage synchronizer. A one-deep transmit buffer lets the host queue the next word while the current one shifts. The slave's return line can drive actively or work in open-drain style. Every pin output rests at logic 1 while the port is disabled.

Top module: `sync_serial_port`

## Requirements
- R1: In master mode a finished word places in `rx_data` the bits sampled on `miso_i`, and `mosi_o` carries the low W bits of the written word, for all four `cpol`/`cpha` settings. With `cpha`=0 the leading edge (the first edge away from the idle level `cpol`) samples and the trailing edge shifts. With `cpha`=1 the leading edge shifts and the trailing edge samples.
- R2: An enabled master with no word started holds `sclk_o` at `cpol`. After a transmit write, `mosi_o` and `sclk_o` do not change until the first `baud_tick`.
- R3: In slave mode, loading a word into the shift register drives its first bit on `miso_o` in the very next clock cycle, before any serial clock edge.
- R4: In slave mode the port shifts under the external `sclk_i` with the same edge rules as R1: it returns the loaded word on its data output and collects the `mosi_i` bits in `rx_data`.
- R5: `rx_full` rises when the W-th bit completes, in both modes, and `rx_clr` clears it.
- R6: After a master word ends, `mosi_o` keeps the level of the last bit sent until the next word starts.
- R7: While `enable` is 0, `sclk_o`, `mosi_o` and `miso_o` are 1 and all three output enables are 0.
- R8: With `open_drain`=1 a slave drives `miso_oe`=1 with `miso_o`=0 for a zero bit, and releases the line (`miso_oe`=0) for a one bit.
- R9: The word width W is `wsel`+1 for `wsel` from 1 to 15, and `wsel`=0 selects 2. Bits of `rx_data` at W and above read 0.
- R10: A write while `busy` is 1 is held in the transmit buffer and drops `tx_empty` to 0. When the current word ends, the buffered word moves into the shift register, `tx_empty` returns to 1 and `busy` stays 1. `busy` falls only when a word ends with no word queued.
- R11: When a slave word ends with no queued data, the received word stays in the shift register. Its first bit is presented at once and it is shifted out in the next transfer.
- R12: `msb_first`=1 sends and receives the most significant bit first. `msb_first`=0 sends and receives the least significant bit first.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Core clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| enable | input | 1 | Port enable; pins idle high when 0 |
| master | input | 1 | 1 = clock master, 0 = slave |
| cpol | input | 1 | Idle level of the serial clock |
| cpha | input | 1 | Clock phase select |
| msb_first | input | 1 | Bit order select |
| wsel | input | 4 | Word width code |
| open_drain | input | 1 | Open-drain style for the slave return line |
| baud_tick | input | 1 | Master half-bit timing pulse |
| tx_wr | input | 1 | Transmit write strobe |
| tx_wdata | input | 16 | Transmit word |
| rx_clr | input | 1 | Clears the receive-complete flag |
| rx_data | output | 16 | Last received word |
| rx_full | output | 1 | Receive-complete flag |
| tx_empty | output | 1 | Transmit buffer free |
| busy | output | 1 | Word loaded and not yet complete |
| sclk_i | input | 1 | Serial clock input (slave) |
| sclk_o | output | 1 | Serial clock output (master) |
| sclk_oe | output | 1 | Serial clock output enable |
| mosi_i | input | 1 | Master-out line input (slave) |
| mosi_o | output | 1 | Master-out line output (master) |
| mosi_oe | output | 1 | Master-out output enable |
| miso_i | input | 1 | Master-in line input (master) |
| miso_o | output | 1 | Master-in line output (slave) |
| miso_oe | output | 1 | Master-in output enable |

## Verification
A wrong bit counter or a wrong edge choice shows up in the same word. It lands as a shifted or rotated `rx_data` value when `rx_full` rises, or as a missing or extra edge on `sclk_o` that the bench model of the far end counts. A stale transmit buffer or a lost handoff appears at the end of the first word, when `tx_empty` and `busy` disagree with the writes made. A held output level that is wrong is visible on the pins in the cycle after the event that should have set it.

// File: rtl/sync_serial_port.sv
module sync_serial_port #(
  parameter int DW = 16
) (
  input  logic                    clk,
  input  logic                    rst_n,
  input  logic                    enable,
  input  logic                    master,
  input  logic                    cpol,
  input  logic                    cpha,
  input  logic                    msb_first,
  input  logic [$clog2(DW)-1:0]   wsel,
  input  logic                    open_drain,
  input  logic                    baud_tick,
  input  logic                    tx_wr,
  input  logic [DW-1:0]           tx_wdata,
  input  logic                    rx_clr,
  output logic [DW-1:0]           rx_data,
  output logic                    rx_full,
  output logic                    tx_empty,
  output logic                    busy,
  input  logic                    sclk_i,
  output logic                    sclk_o,
  output logic                    sclk_oe,
  input  logic                    mosi_i,
  output logic                    mosi_o,
  output logic                    mosi_oe,
  input  logic                    miso_i,
  output logic                    miso_o,
  output logic                    miso_oe
);
  localparam int CW = $clog2(DW + 1);

  function automatic logic obit(input logic [DW-1:0] v, input logic [CW-1:0] w, input logic m);
    return m ? v[w - CW'(1)] : v[0];
  endfunction

  function automatic logic [DW-1:0] shl(input logic [DW-1:0] v, input logic b,
                                        input logic [CW-1:0] w, input logic m,
                                        input logic [DW-1:0] mk);
    if (m) return ((v << 1) | DW'(b)) & mk;
    return ((v & mk) >> 1) | (DW'(b) << (w - CW'(1)));
  endfunction

  logic [CW-1:0] wid, n_q;
  logic [DW-1:0] mask, sh_q, tbuf_q, rx_q, sh_sft, sh_smp, res;
  logic tx_empty_q, busy_q, rx_full_q, st_q, din_q, sclk_q, mosi_q, miso_q;
  logic [2:0] ck_s;
  logic [1:0] d_s;
  logic in_bit, m_act, m_lead, m_tog, m_sft, m_smp;
  logic s_edge, s_lead, s_sft, s_smp, sft_ev, smp_ev, fin_sft, fin_smp, done;

  assign wid  = (wsel == '0) ? CW'(2) : CW'(wsel) + CW'(1);
  assign mask = {DW{1'b1}} >> (CW'(DW) - wid);

  assign m_act  = enable & master & busy_q & baud_tick;
  assign m_lead = (sclk_q == cpol);
  assign m_tog  = m_act & (st_q | cpha);
  assign m_sft  = m_act & (~st_q | (m_lead == cpha));
  assign m_smp  = m_act & st_q & (m_lead != cpha);

  assign s_edge = enable & ~master & (ck_s[1] ^ ck_s[2]);
  assign s_lead = (ck_s[2] == cpol);
  assign s_smp  = s_edge & (s_lead != cpha);
  assign s_sft  = s_edge & (s_lead == cpha);

  assign sft_ev = m_sft | s_sft;
  assign smp_ev = m_smp | s_smp;
  assign in_bit = master ? miso_i : d_s[1];
  assign sh_sft = shl(sh_q, din_q, wid, msb_first, mask);
  assign sh_smp = shl(sh_q, in_bit, wid, msb_first, mask);

  assign fin_sft = sft_ev & ~cpha & (n_q == wid);
  assign fin_smp = smp_ev & cpha & ((n_q + CW'(1)) == wid);
  assign done    = fin_sft | fin_smp;
  assign res     = fin_smp ? sh_smp : sh_sft;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ck_s       <= '0;
      d_s        <= '0;
      sh_q       <= '0;
      tbuf_q     <= '0;
      rx_q       <= '0;
      n_q        <= '0;
      tx_empty_q <= 1'b1;
      busy_q     <= 1'b0;
      rx_full_q  <= 1'b0;
      st_q       <= 1'b0;
      din_q      <= 1'b0;
      sclk_q     <= 1'b0;
      mosi_q     <= 1'b1;
      miso_q     <= 1'b1;
    end else begin
      ck_s <= {ck_s[1:0], sclk_i};
      d_s  <= {d_s[0], mosi_i};
      if (rx_clr) rx_full_q <= 1'b0;

      if (m_tog) sclk_q <= ~sclk_q;
      else if (!st_q) sclk_q <= cpol;
      if (m_act) st_q <= 1'b1;

      if (smp_ev) begin
        din_q  <= in_bit;
        n_q    <= n_q + CW'(1);
        busy_q <= 1'b1;
      end

      if (sft_ev) begin
        busy_q <= 1'b1;
        if (n_q != '0 && n_q != wid) sh_q <= sh_sft;
        if (n_q != wid) begin
          if (master) mosi_q <= obit((n_q == '0) ? sh_q : sh_sft, wid, msb_first);
          else        miso_q <= obit((n_q == '0) ? sh_q : sh_sft, wid, msb_first);
        end
      end

      if (done) begin
        rx_q      <= res & mask;
        rx_full_q <= 1'b1;
        n_q       <= '0;
        st_q      <= 1'b0;
        if (!tx_empty_q) begin
          sh_q       <= tbuf_q;
          tx_empty_q <= 1'b1;
          busy_q     <= 1'b1;
          if (!master) miso_q <= obit(tbuf_q, wid, msb_first);
        end else begin
          sh_q   <= res;
          busy_q <= 1'b0;
          if (!master) miso_q <= obit(res, wid, msb_first);
        end
      end

      if (tx_wr) begin
        if (!busy_q || (done && tx_empty_q)) begin
          sh_q   <= tx_wdata;
          busy_q <= 1'b1;
          if (!master) miso_q <= obit(tx_wdata, wid, msb_first);
        end else begin
          tbuf_q     <= tx_wdata;
          tx_empty_q <= 1'b0;
        end
      end
    end
  end

  assign rx_data  = rx_q;
  assign rx_full  = rx_full_q;
  assign tx_empty = tx_empty_q;
  assign busy     = busy_q;

  assign sclk_oe = enable & master;
  assign mosi_oe = enable & master;
  assign sclk_o  = (enable & master) ? sclk_q : 1'b1;
  assign mosi_o  = (enable & master) ? mosi_q : 1'b1;
  assign miso_o  = (enable & ~master) ? miso_q : 1'b1;
  assign miso_oe = enable & ~master & (~open_drain | ~miso_q);

  AST_BITCOUNT_IN_WIDTH: assert property (@(posedge clk) disable iff (!rst_n)
    n_q <= wid); // R9
  AST_RXFULL_AFTER_WORD: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(rx_full_q) |-> $past(busy_q)); // R5
  AST_MASTER_DATA_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    (master && !busy_q) |=> $stable(mosi_q)); // R6
  AST_IDLE_MEANS_EMPTY: assert property (@(posedge clk) disable iff (!rst_n)
    !busy_q |-> tx_empty_q); // R10
endmodule

// File: tb/sync_serial_port_tb.sv
module sync_serial_port_tb_top;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  always #4 clk = ~clk;

  logic enable = 0, master = 1, cpol = 0, cpha = 0, msb_first = 1, open_drain = 0;
  logic [3:0] wsel = 4'd7;
  logic baud_tick = 0, tx_wr = 0, rx_clr = 0;
  logic [15:0] tx_wdata = '0;
  logic [15:0] rx_data;
  logic rx_full, tx_empty, busy;
  logic sclk_i = 0, mosi_i = 0, miso_i = 1;
  logic sclk_o, sclk_oe, mosi_o, mosi_oe, miso_o, miso_oe;

  sync_serial_port dut_i (
    .clk(clk), .rst_n(rst_n), .enable(enable), .master(master), .cpol(cpol), .cpha(cpha),
    .msb_first(msb_first), .wsel(wsel), .open_drain(open_drain), .baud_tick(baud_tick),
    .tx_wr(tx_wr), .tx_wdata(tx_wdata), .rx_clr(rx_clr), .rx_data(rx_data),
    .rx_full(rx_full), .tx_empty(tx_empty), .busy(busy), .sclk_i(sclk_i), .sclk_o(sclk_o),
    .sclk_oe(sclk_oe), .mosi_i(mosi_i), .mosi_o(mosi_o), .mosi_oe(mosi_oe),
    .miso_i(miso_i), .miso_o(miso_o), .miso_oe(miso_oe));

  int n_chk = 0, n_fail = 0;
  bit finished = 0;

  // baud tick: one pulse every 4 cycles while enabled
  logic tick_en = 0;
  int tick_cnt = 0;
  always @(negedge clk) begin
    tick_cnt  = (tick_cnt + 1) % 4;
    baud_tick = tick_en && (tick_cnt == 0);
  end

  // model of the far-end slave for master tests
  int bm_w = 8;
  logic [15:0] bm_pat = '0;
  int bm_req = 0, bm_seen = 0, bm_sc = 0, bm_capn = 0;
  logic [15:0] bm_cap = '0;
  logic bm_prev = 0;

  function automatic int bpos(int k, int w, bit m);
    return m ? (w - 1 - k) : k;
  endfunction

  always @(negedge clk) begin
    if (bm_req != bm_seen) begin
      bm_seen = bm_req;
      bm_sc = 0; bm_capn = 0; bm_cap = '0;
      miso_i = bm_pat[bpos(0, bm_w, msb_first)];
    end else if (master && sclk_o !== bm_prev) begin
      if ((bm_prev == cpol) ^ cpha) begin
        if (bm_capn < bm_w) bm_cap[bpos(bm_capn, bm_w, msb_first)] = mosi_o;
        bm_capn++;
      end else begin
        if (!cpha) begin
          if (bm_sc + 1 < bm_w) miso_i = bm_pat[bpos(bm_sc + 1, bm_w, msb_first)];
        end else if (bm_sc < bm_w) miso_i = bm_pat[bpos(bm_sc, bm_w, msb_first)];
        bm_sc++;
      end
    end
    bm_prev = sclk_o;
  end

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  function automatic int wfor(input logic [3:0] s);
    return (s == 0) ? 2 : int'(s) + 1;
  endfunction

  task automatic cyc(input int k);
    repeat (k) @(negedge clk);
  endtask

  task automatic write_tx(input logic [15:0] d);
    tx_wdata = d; tx_wr = 1; cyc(1); tx_wr = 0;
  endtask

  task automatic clear_rx();
    rx_clr = 1; cyc(1); rx_clr = 0;
  endtask

  task automatic bm_start(input logic [15:0] pat, input int w);
    bm_pat = pat; bm_w = w; bm_req++; cyc(2);
  endtask

  task automatic wait_done(input string req);
    int k;
    for (k = 0; k < 3000; k++) begin
      if (rx_full) break;
      cyc(1);
    end
    chk(req, 32'(rx_full), 32'd1);
  endtask

  task automatic slave_xfer(input int w, input logic [15:0] pat, output logic [15:0] cap);
    cap = '0;
    for (int k = 0; k < w; k++) begin
      int p;
      p = bpos(k, w, msb_first);
      if (!cpha) begin
        mosi_i = pat[p]; cyc(8);
        cap[p] = miso_oe ? miso_o : 1'b1;
        sclk_i = ~cpol; cyc(8); sclk_i = cpol;
      end else begin
        sclk_i = ~cpol; mosi_i = pat[p]; cyc(8);
        cap[p] = miso_oe ? miso_o : 1'b1;
        sclk_i = cpol; cyc(8);
      end
    end
    cyc(8);
  endtask

  // wsel, msb, cpol, cpha, tx, pattern from far end
  localparam logic [38:0] VEC [8] = '{
    {4'd7,  1'b1, 1'b0, 1'b0, 16'h00A5, 16'h003C},
    {4'd7,  1'b0, 1'b0, 1'b1, 16'h0096, 16'h00E1},
    {4'd15, 1'b1, 1'b1, 1'b0, 16'hBEEF, 16'h1234},
    {4'd15, 1'b0, 1'b1, 1'b1, 16'h1357, 16'hFACE},
    {4'd1,  1'b1, 1'b0, 1'b1, 16'hFFFE, 16'h0001},
    {4'd4,  1'b0, 1'b1, 1'b0, 16'h0013, 16'h000A},
    {4'd11, 1'b1, 1'b1, 1'b1, 16'h0ABC, 16'h0F0F},
    {4'd0,  1'b0, 1'b0, 1'b0, 16'h0002, 16'h0003}
  };

  task automatic tests();
    logic [15:0] cap, mk;
    int w;
    cyc(3); rst_n = 1; cyc(2);
    // R7 reset / disabled state
    chk("R7 sclk_o", 32'(sclk_o), 1); chk("R7 mosi_o", 32'(mosi_o), 1);
    chk("R7 miso_o", 32'(miso_o), 1);
    chk("R7 oe", {29'd0, sclk_oe, mosi_oe, miso_oe}, 0);
    chk("R10 reset flags", {29'd0, tx_empty, busy, rx_full}, 32'b100);

    // R2 idle level and tick gating
    enable = 1; master = 1; cpol = 0; cyc(2);
    chk("R2 idle low", 32'(sclk_o), 0);
    cpol = 1; cyc(2);
    chk("R2 idle high", 32'(sclk_o), 1);
    cpol = 0; cyc(2);
    bm_start(16'h0055, 8);
    write_tx(16'h0000); cyc(20);
    chk("R2 no bit before tick", 32'(mosi_o), 1);
    chk("R2 no clock before tick", 32'(sclk_o), 0);
    chk("R10 busy after load", 32'(busy), 1);
    tick_en = 1;
    wait_done("R5 master done"); cyc(1);
    chk("R1 rx word", 32'(rx_data), 32'h55);
    chk("R1 tx word", 32'(bm_cap), 32'h00);
    clear_rx();
    chk("R5 cleared", 32'(rx_full), 0);

    // R1 R12 R9 R6 vector walk
    foreach (VEC[i]) begin
      wsel = VEC[i][38:35]; msb_first = VEC[i][34]; cpol = VEC[i][33]; cpha = VEC[i][32];
      w = wfor(wsel);
      mk = 16'((17'd1 << w) - 17'd1);
      cyc(3);
      bm_start(VEC[i][15:0], w);
      write_tx(VEC[i][31:16]);
      wait_done("R5 vector done"); cyc(1);
      chk("R1 R12 rx word", 32'(rx_data), 32'(VEC[i][15:0] & mk));
      chk("R1 R12 tx word", 32'(bm_cap), 32'(VEC[i][31:16] & mk));
      chk("R9 upper bits zero", 32'(rx_data & ~mk), 0);
      chk("R6 last bit held", 32'(mosi_o), 32'(VEC[i][16 + bpos(w - 1, w, msb_first)]));
      chk("R2 clock back idle", 32'(sclk_o), 32'(cpol));
      chk("R10 idle after word", {30'd0, busy, tx_empty}, 32'b01);
      clear_rx();
    end

    // R10 queued word handoff
    wsel = 4'd7; msb_first = 1; cpol = 0; cpha = 0; cyc(3);
    bm_start(16'h0011, 8);
    write_tx(16'h00A1);
    write_tx(16'h007E);
    chk("R10 buffer full", 32'(tx_empty), 0);
    wait_done("R5 first queued");
    chk("R10 handoff", {30'd0, busy, tx_empty}, 32'b11);
    chk("R5 first word", 32'(rx_data), 32'h11);
    bm_pat = 16'h0022; bm_req++;
    clear_rx();
    chk("R5 clear", 32'(rx_full), 0);
    wait_done("R5 second queued"); cyc(1);
    chk("R10 second rx", 32'(rx_data), 32'h22);
    chk("R10 second tx", 32'(bm_cap), 32'h7E);
    chk("R10 idle", 32'(busy), 0);
    clear_rx(); tick_en = 0;

    // slave, open drain, cpha0, msb, 8 bits
    enable = 0; master = 0; open_drain = 1; sclk_i = 0; mosi_i = 0; cyc(6);
    enable = 1; cyc(2);
    write_tx(16'h005A);
    chk("R3 R8 first bit driven low", {30'd0, miso_oe, miso_o}, 32'b10);
    slave_xfer(8, 16'h00C3, cap);
    chk("R4 slave sent", 32'(cap), 32'h5A);
    chk("R4 slave received", 32'(rx_data), 32'hC3);
    chk("R5 slave flag", 32'(rx_full), 1);
    chk("R8 R11 one released", 32'(miso_oe), 0);
    clear_rx();
    slave_xfer(8, 16'h000F, cap);
    chk("R11 previous word out", 32'(cap), 32'hC3);
    chk("R11 rx", 32'(rx_data), 32'h0F);
    clear_rx();

    // slave, push-pull, cpha1, lsb, 12 bits, idle high
    enable = 0; open_drain = 0; cpol = 1; cpha = 1; msb_first = 0; wsel = 4'd11;
    sclk_i = 1; cyc(6); enable = 1; cyc(2);
    write_tx(16'h0ABC);
    chk("R3 first bit at once", {30'd0, miso_oe, miso_o}, 32'b10);
    slave_xfer(12, 16'h0123, cap);
    chk("R4 R12 slave sent", 32'(cap), 32'hABC);
    chk("R4 R12 slave received", 32'(rx_data), 32'h123);

    // R7 disable again
    enable = 0; cyc(2);
    chk("R7 all high", {29'd0, sclk_o, mosi_o, miso_o}, 32'b111);
    chk("R7 all released", {29'd0, sclk_oe, mosi_oe, miso_oe}, 0);
  endtask

  initial begin
    fork
      begin tests(); finished = 1; end
      begin repeat (190000) @(posedge clk); end
    join_any
    disable fork;
    if (!finished) begin
      n_chk++; n_fail++;
      $display("FAIL watchdog actual=running expected=finished");
    end
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end
endmodule